// File: doc/BRIEF.md
# Dual-Clock Decade Up/Down Counter

This block keeps a single decimal digit, 0 through 9, and steps it from two separate count inputs: one pin that counts up and one that counts down. Each pin counts on its rising edge, but only while the other pin sits high. Both pins are sampled by one system clock through two-flop synchronizers, so the pins may come from any clock domain. A count event is taken on a detected rising edge, at most one step per system clock.

A master clear (active high) forces the digit to zero and overrides everything else. An active-low load input copies a 4-bit preset bus into the digit on every system clock while it is held low, with no count edge needed. Two active-low terminal outputs let digits be chained. The carry output is low while the digit is 9 and the up pin is low, so it falls half a count period before the wrap. The borrow output is low while the digit is 0 and the down pin is low. All outputs are registered.

Top module: `bcd_dual_clk_counter`

## Requirements
- R1: While `rst` is high, and on the first clock after it, `q` is 0 and both `carry_n` and `borrow_n` are 1.
- R2: `mr` high clears `q` to 0 on the next system clock. This takes priority over a low `pl_n` and over any count event.
- R3: While `pl_n` is low and `mr` is low, `q` takes the value of `preset` on every system clock. A count event in that time has no effect.
- R4: A rising edge on `up_pin` while `dn_pin` is high adds one to `q`. The new value appears on the third system clock edge after the pin changes.
- R5: A rising edge on `dn_pin` while `up_pin` is high subtracts one from `q`, with the same latency as R4.
- R6: Counting up from 9 gives 0. Counting down from 0 gives 9.
- R7: After a preset of 10 to 15, the next up count gives 0 and the next down count gives 9.
- R8: `carry_n` is 0 exactly when `q` is 9 and the synchronized `up_pin` is low. It is 1 otherwise, including for values 10 to 15.
- R9: `borrow_n` is 0 exactly when `q` is 0 and the synchronized `dn_pin` is low. It is 1 otherwise.
- R10: A rising edge on one count pin while the other pin is low leaves `q` unchanged.
- R11: If rising edges on both count pins are detected in the same system clock, `q` is unchanged.
- R12: Between two system clocks, `q` either stays the same or moves by one legal step, unless `mr` or a load is active.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous system reset, active high |
| mr | input | 1 | Master clear, active high |
| pl_n | input | 1 | Parallel load, active low |
| preset | input | 4 | Value to load |
| up_pin | input | 1 | Count-up input (counts on rising edge) |
| dn_pin | input | 1 | Count-down input (counts on rising edge) |
| q | output | 4 | Current digit |
| carry_n | output | 1 | Terminal count up, active low |
| borrow_n | output | 1 | Terminal count down, active low |

## Verification
Two pairs of functions can collide in one system clock. The first pair is an up edge and a down edge. The bench provokes this by dropping both pins and then raising both in the same cycle, and it judges the result by the digit staying put. The second pair is a load or clear against a count edge. The bench pulses a count pin while `pl_n` or `mr` is held, and it judges the result by the digit showing the preset or zero rather than a stepped value.

// File: rtl/bcd_cnt_pkg.sv
package bcd_cnt_pkg;

  typedef enum logic [1:0] {
    STEP_HOLD = 2'd0,
    STEP_UP   = 2'd1,
    STEP_DOWN = 2'd2
  } step_e;

  // Successor of a digit; anything at or above the top value wraps to zero.
  function automatic logic [7:0] dig_inc(input logic [7:0] cur, input logic [7:0] top);
    return (cur >= top) ? 8'd0 : cur + 8'd1;
  endfunction

  // Predecessor of a digit; zero and invalid values go to the top value.
  function automatic logic [7:0] dig_dec(input logic [7:0] cur, input logic [7:0] top);
    return (cur == 8'd0 || cur > top) ? top : cur - 8'd1;
  endfunction

endpackage

// File: rtl/cnt_pin_sync.sv
module cnt_pin_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic pin,
  output logic lvl,
  output logic lvl_nxt,
  output logic rise
);
  // Synchronizer stages plus one extra flop for edge detection.
  logic [STAGES:0] sh;

  always_ff @(posedge clk) begin
    if (rst) sh <= '1;
    else     sh <= {sh[STAGES-1:0], pin};
  end

  assign lvl     = sh[STAGES-1];
  assign lvl_nxt = sh[STAGES-2];
  assign rise    = sh[STAGES-1] & ~sh[STAGES];
endmodule

// File: rtl/cnt_step_sel.sv
module cnt_step_sel
  import bcd_cnt_pkg::*;
(
  input  logic  up_rise,
  input  logic  up_lvl,
  input  logic  dn_rise,
  input  logic  dn_lvl,
  output step_e step
);
  logic up_ev, dn_ev;

  // An edge counts only while the opposite pin is high.
  assign up_ev = up_rise & dn_lvl;
  assign dn_ev = dn_rise & up_lvl;

  always_comb begin
    unique case ({up_ev, dn_ev})
      2'b10:   step = STEP_UP;
      2'b01:   step = STEP_DOWN;
      default: step = STEP_HOLD;
    endcase
  end
endmodule

// File: rtl/bcd_next_val.sv
module bcd_next_val
  import bcd_cnt_pkg::*;
#(
  parameter int W    = 4,
  parameter int LAST = 9
) (
  input  logic [W-1:0] cur,
  input  step_e        step,
  input  logic         mr,
  input  logic         pl_n,
  input  logic [W-1:0] preset,
  output logic [W-1:0] nxt
);
  localparam logic [7:0] TOP = 8'(LAST);

  logic [7:0] cur8, inc8, dec8;

  assign cur8 = 8'(cur);
  assign inc8 = dig_inc(cur8, TOP);
  assign dec8 = dig_dec(cur8, TOP);

  always_comb begin
    if (mr)         nxt = '0;
    else if (!pl_n) nxt = preset;
    else begin
      unique case (step)
        STEP_UP:   nxt = inc8[W-1:0];
        STEP_DOWN: nxt = dec8[W-1:0];
        default:   nxt = cur;
      endcase
    end
  end
endmodule

// File: rtl/bcd_dual_clk_counter.sv
module bcd_dual_clk_counter
  import bcd_cnt_pkg::*;
#(
  parameter int W           = 4,
  parameter int LAST        = 9,
  parameter int SYNC_STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         mr,
  input  logic         pl_n,
  input  logic [W-1:0] preset,
  input  logic         up_pin,
  input  logic         dn_pin,
  output logic [W-1:0] q,
  output logic         carry_n,
  output logic         borrow_n
);
  localparam int NPIN = 2;  // index 0 = up, 1 = down
  localparam logic [W-1:0] TOPV = W'(LAST);

  logic [NPIN-1:0] pins, lvl, lvl_nxt, rise;
  step_e           step;
  logic [W-1:0]    nxt;

  assign pins = {dn_pin, up_pin};

  for (genvar i = 0; i < NPIN; i++) begin : g_sync
    cnt_pin_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk     (clk),
      .rst     (rst),
      .pin     (pins[i]),
      .lvl     (lvl[i]),
      .lvl_nxt (lvl_nxt[i]),
      .rise    (rise[i])
    );
  end

  cnt_step_sel u_sel (
    .up_rise (rise[0]),
    .up_lvl  (lvl[0]),
    .dn_rise (rise[1]),
    .dn_lvl  (lvl[1]),
    .step    (step)
  );

  bcd_next_val #(.W(W), .LAST(LAST)) u_next (
    .cur    (q),
    .step   (step),
    .mr     (mr),
    .pl_n   (pl_n),
    .preset (preset),
    .nxt    (nxt)
  );

  // Terminal outputs registered alongside the digit, using the next
  // synchronized pin level so that both stay aligned with q.
  always_ff @(posedge clk) begin
    if (rst) begin
      q        <= '0;
      carry_n  <= 1'b1;
      borrow_n <= 1'b1;
    end else begin
      q        <= nxt;
      carry_n  <= !((nxt == TOPV) && !lvl_nxt[0]);
      borrow_n <= !((nxt == '0)   && !lvl_nxt[1]);
    end
  end
endmodule

// File: rtl/bcd_counter_chk.sv
module bcd_counter_chk
  import bcd_cnt_pkg::*;
#(
  parameter int W    = 4,
  parameter int LAST = 9
) (
  input logic         clk,
  input logic         rst,
  input logic         mr,
  input logic         pl_n,
  input logic [W-1:0] preset,
  input logic [W-1:0] q,
  input logic         carry_n,
  input logic         borrow_n
);
  localparam logic [7:0] TOP = 8'(LAST);

  p_clear_r2: assert property (@(posedge clk) disable iff (rst)
    mr |=> (q == '0));

  p_load_r3: assert property (@(posedge clk) disable iff (rst)
    (!mr && !pl_n) |=> (q == $past(preset)));

  p_carry_r8: assert property (@(posedge clk) disable iff (rst)
    !carry_n |-> (8'(q) == TOP));

  p_borrow_r9: assert property (@(posedge clk) disable iff (rst)
    !borrow_n |-> (q == '0));

  p_step_r12: assert property (@(posedge clk) disable iff (rst)
    (!$past(mr) && $past(pl_n) && !$past(rst) && (q != $past(q))) |->
      ((8'(q) == dig_inc(8'($past(q)), TOP)) || (8'(q) == dig_dec(8'($past(q)), TOP))));

  p_reset_r1: assert property (@(posedge clk)
    $past(rst) |-> (q == '0 && carry_n && borrow_n));
endmodule

bind bcd_dual_clk_counter bcd_counter_chk #(.W(W), .LAST(LAST)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .mr       (mr),
  .pl_n     (pl_n),
  .preset   (preset),
  .q        (q),
  .carry_n  (carry_n),
  .borrow_n (borrow_n)
);

// File: tb/sim_bcd_dual_clk_counter.sv
`timescale 1ns/100ps
module sim_bcd_dual_clk_counter;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       mr = 1'b0;
  logic       pl_n = 1'b1;
  logic [3:0] preset = 4'd0;
  logic       up_pin = 1'b1;
  logic       dn_pin = 1'b1;
  logic [3:0] q;
  logic       carry_n, borrow_n;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  always #2.5 clk = ~clk;

  bcd_dual_clk_counter u0 (
    .clk(clk), .rst(rst), .mr(mr), .pl_n(pl_n), .preset(preset),
    .up_pin(up_pin), .dn_pin(dn_pin), .q(q), .carry_n(carry_n), .borrow_n(borrow_n)
  );

  // op: 0 load d, 1 up pulse, 2 down pulse, 3 master clear
  typedef struct packed { logic [1:0] op; logic [3:0] d; logic [3:0] eq; } vec_t;
  localparam int NV = 13;
  localparam vec_t VT [NV] = '{
    '{2'd0, 4'd7,  4'd7},  '{2'd1, 4'd0, 4'd8},  '{2'd1, 4'd0, 4'd9},
    '{2'd1, 4'd0,  4'd0},  '{2'd2, 4'd0, 4'd9},  '{2'd2, 4'd0, 4'd8},
    '{2'd0, 4'd0,  4'd0},  '{2'd2, 4'd0, 4'd9},  '{2'd0, 4'd12, 4'd12},
    '{2'd1, 4'd0,  4'd0},  '{2'd0, 4'd15, 4'd15}, '{2'd2, 4'd0, 4'd9},
    '{2'd3, 4'd0,  4'd0}
  };

  task automatic waitn(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic do_load(input logic [3:0] v);
    preset = v; pl_n = 1'b0; waitn(3); pl_n = 1'b1; waitn(2);
  endtask

  task automatic up_pulse();
    up_pin = 1'b0; waitn(4); up_pin = 1'b1; waitn(4);
  endtask

  task automatic dn_pulse();
    dn_pin = 1'b0; waitn(4); dn_pin = 1'b1; waitn(4);
  endtask

  initial begin
    waitn(3);
    chk("R1 q", int'(q), 0);
    chk("R1 carry_n", int'(carry_n), 1);
    chk("R1 borrow_n", int'(borrow_n), 1);
    rst = 1'b0;
    waitn(1);
    chk("R1 q after release", int'(q), 0);

    for (int k = 0; k < NV; k++) begin
      case (VT[k].op)
        2'd0: do_load(VT[k].d);
        2'd1: up_pulse();
        2'd2: dn_pulse();
        default: begin mr = 1'b1; waitn(2); mr = 1'b0; waitn(2); end
      endcase
      case (VT[k].op)
        2'd0: chk("R3 table load", int'(q), int'(VT[k].eq));
        2'd1: chk("R4/R6/R7 table up", int'(q), int'(VT[k].eq));
        2'd2: chk("R5/R6/R7 table down", int'(q), int'(VT[k].eq));
        default: chk("R2 table clear", int'(q), int'(VT[k].eq));
      endcase
    end

    // R6 up wrap, directed
    do_load(4'd9); up_pulse();
    chk("R6 up 9->0", int'(q), 0);
    dn_pulse();
    chk("R6 down 0->9", int'(q), 9);

    // R7 invalid preset
    do_load(4'd10); up_pulse();
    chk("R7 up from 10", int'(q), 0);
    do_load(4'd13); dn_pulse();
    chk("R7 down from 13", int'(q), 9);

    // R4 latency: value appears on third edge after pin rise
    do_load(4'd3);
    up_pin = 1'b0; waitn(4); up_pin = 1'b1;
    waitn(2);
    chk("R4 not yet after 2 edges", int'(q), 3);
    waitn(1);
    chk("R4 after 3 edges", int'(q), 4);
    waitn(2);

    // R3 load follows preset and blocks counting
    preset = 4'd2; pl_n = 1'b0; waitn(2);
    chk("R3 follow 2", int'(q), 2);
    preset = 4'd6; waitn(1);
    chk("R3 follow 6", int'(q), 6);
    up_pin = 1'b0; waitn(4); up_pin = 1'b1; waitn(4);
    chk("R3 count blocked by load", int'(q), 6);
    pl_n = 1'b1; waitn(2);

    // R2 clear beats load and counting
    preset = 4'd8; pl_n = 1'b0; mr = 1'b1;
    up_pin = 1'b0; waitn(4); up_pin = 1'b1; waitn(4);
    chk("R2 clear over load", int'(q), 0);
    mr = 1'b0; pl_n = 1'b1; waitn(2);

    // R8 carry
    do_load(4'd9);
    chk("R8 carry high with up high", int'(carry_n), 1);
    up_pin = 1'b0; waitn(3);
    chk("R8 carry low at 9, up low", int'(carry_n), 0);
    chk("R9 borrow idle at 9", int'(borrow_n), 1);
    up_pin = 1'b1; waitn(4);
    chk("R8 carry after wrap", int'(carry_n), 1);
    chk("R8 wrapped value", int'(q), 0);
    do_load(4'd12); up_pin = 1'b0; waitn(3);
    chk("R8 no carry at 12", int'(carry_n), 1);
    up_pin = 1'b1; waitn(4);

    // R9 borrow
    do_load(4'd0);
    dn_pin = 1'b0; waitn(3);
    chk("R9 borrow low at 0", int'(borrow_n), 0);
    chk("R8 carry idle at 0", int'(carry_n), 1);
    dn_pin = 1'b1; waitn(4);
    chk("R9 borrow after wrap", int'(borrow_n), 1);
    chk("R9 wrapped value", int'(q), 9);

    // R10 blocked edges
    do_load(4'd5);
    dn_pin = 1'b0; waitn(4);
    up_pin = 1'b0; waitn(4);
    up_pin = 1'b1; waitn(4);
    chk("R10 up edge with down low", int'(q), 5);
    up_pin = 1'b0; waitn(4);
    dn_pin = 1'b1; waitn(4);
    chk("R10 down edge with up low", int'(q), 5);
    up_pin = 1'b1; waitn(4);
    chk("R4 up after release", int'(q), 6);

    // R11 simultaneous edges
    up_pin = 1'b0; dn_pin = 1'b0; waitn(4);
    up_pin = 1'b1; dn_pin = 1'b1; waitn(5);
    chk("R11 both edges", int'(q), 6);

    done = 1;
  end

  initial begin
    for (int c = 0; c < 20000; c++) begin
      @(posedge clk);
      if (done) break;
    end
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: actual=hung expected=finished");
    end
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule